// File: doc/BRIEF.md
# Two-Level Write Protection Controller

This block sits between the serial bit engine of a 256-byte two-wire memory and its storage array. The engine decodes each control byte. It then hands the block the upper four bits (the command class), the three device-select bits and the read/write bit. The block answers with an acknowledge decision. During a write session, the engine presents each incoming data byte's word address. The block answers each one with a write enable that says whether the array may take the byte.

Three sources of protection are combined:
- A permanent flag that can only ever be set. It guards the lower half of the array.
- A reversible flag that can be set and cleared. It guards the same lower half.
- A hardware protect pin. It guards the whole array.

Both flags are changed by special commands, and their status is read back only as ACK or NACK. A flag change is held as pending and commits only when the engine reports a valid stop. A one-cycle commit strobe then tells the nonvolatile store to schedule its program cycle.

The request side has no back-pressure: the engine cannot stall, so there is no ready signal. Every `cmd_valid_i` pulse produces a `dec_valid_o` pulse exactly one cycle later. Every `wr_req_i` pulse is answered by `wr_en_o` one cycle later. `rst_n` is the power-on reset and the only thing that clears the flags.

Top module: `wp_guard`

## Requirements
- R1: A command with class 1010 and device bits equal to `strap_i` is acknowledged, whatever the flags and the pin hold. A class of 1010 with mismatched device bits, or any class other than 1010 and 0110, is not acknowledged.
- R2: When either flag is set, a write request to a word address whose most significant bit is 0 (00h–7Fh) gets `wr_en_o`=0. Addresses 80h–FFh keep `wr_en_o`=1.
- R3: While `wp_pin_i` is 1, every write request gets `wr_en_o`=0. A write request outside an acknowledged 1010 write session (read/write bit 0) also gets 0.
- R4: With `hv_a0_i`=0, class 0110 with device bits equal to `strap_i` and read/write bit 0 is acknowledged while the permanent flag is clear. That command sets the permanent flag at the following stop.
- R5: Once the permanent flag is set, every class 0110 command with `hv_a0_i`=0 and matching device bits is not acknowledged. Only the power-on reset clears the flag.
- R6: With `hv_a0_i`=1, class 0110 with device bits 001 and read/write bit 0 sets the reversible flag at the following stop. The command is not acknowledged if that flag is already set.
- R7: With `hv_a0_i`=1, class 0110 with device bits 011 and read/write bit 0 is always acknowledged. It clears the reversible flag at the following stop.
- R8: A status read is the set command sent with read/write bit 1. It is acknowledged exactly when the addressed flag is clear, and it changes no flag.
- R9: A flag change commits only if `wp_pin_i` is 0 in the cycle of the stop. The set and clear commands are still acknowledged while the pin is high.
- R10: A pending flag change is dropped if a new command arrives before the stop. `commit_o` pulses for one cycle, one cycle after a stop that commits a change.
- R11: `dec_valid_o` is high exactly one cycle after `cmd_valid_i`, and `ack_o` is valid in that cycle. `wr_en_o` answers `wr_req_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid_i | input | 1 | One-cycle pulse: a decoded control byte is present |
| cls_i | input | 4 | Command class (upper nibble of the control byte) |
| dev_i | input | 3 | Device-select bits of the control byte |
| rw_i | input | 1 | Read/write bit, 1 = read |
| strap_i | input | 3 | Strapped device address |
| hv_a0_i | input | 1 | Address pin 0 is at high voltage |
| wp_pin_i | input | 1 | Hardware protect pin, 1 = protect all |
| stop_i | input | 1 | One-cycle pulse: valid stop seen |
| wr_req_i | input | 1 | One-cycle pulse: data byte to be written |
| wr_addr_i | input | 8 | Word address of that byte |
| dec_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| wr_en_o | output | 1 | Array byte may be written |
| commit_o | output | 1 | One-cycle pulse: flag update committed |

## Verification
The bench aims at the addresses on both sides of 80h with each flag set alone. A design that decodes the half boundary on the wrong bit would either lose writes to the upper half or let lower-half writes through. It raises the protect pin during set commands and checks that they are still acknowledged while nothing commits; a design that gated the acknowledge instead would NACK, and one that ignored the pin would set a flag. It sends a new command between a set and its stop, and checks that the dropped change never commits. It also repeats reversible set and status reads around a clear, which catches a flag that does not clear or a status read that disturbs state.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  localparam logic [3:0] CLS_ARRAY = 4'b1010;
  localparam logic [3:0] CLS_PROT  = 4'b0110;
  localparam logic [2:0] DEV_REV_SET = 3'b001;
  localparam logic [2:0] DEV_REV_CLR = 3'b011;

  typedef enum logic [2:0] {
    K_NONE,
    K_ARR_RD,
    K_ARR_WR,
    K_PERM_SET,
    K_PERM_STAT,
    K_REV_SET,
    K_REV_CLR,
    K_REV_STAT
  } cmd_kind_e;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_PERM,
    PEND_REV_SET,
    PEND_REV_CLR
  } pend_e;

endpackage

// File: rtl/wp_cmd_classify.sv
module wp_cmd_classify
  import wp_guard_pkg::*;
#(
  parameter int CLS_W = 4,
  parameter int DEV_W = 3
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             rw_i,
  input  logic [DEV_W-1:0] strap_i,
  input  logic             hv_a0_i,
  input  logic             perm_i,
  input  logic             rev_i,
  output cmd_kind_e        kind_o,
  output logic             ack_o
);

  logic dev_match;
  assign dev_match = (dev_i == strap_i);

  always_comb begin
    kind_o = K_NONE;
    ack_o  = 1'b0;
    if (cls_i == CLS_ARRAY) begin
      if (dev_match) begin
        kind_o = rw_i ? K_ARR_RD : K_ARR_WR;
        ack_o  = 1'b1;
      end
    end else if (cls_i == CLS_PROT) begin
      if (!hv_a0_i) begin
        if (dev_match) begin
          kind_o = rw_i ? K_PERM_STAT : K_PERM_SET;
          ack_o  = !perm_i;
        end
      end else if (dev_i == DEV_REV_SET) begin
        kind_o = rw_i ? K_REV_STAT : K_REV_SET;
        ack_o  = !rev_i;
      end else if (dev_i == DEV_REV_CLR && !rw_i) begin
        kind_o = K_REV_CLR;
        ack_o  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wp_flag_bank.sv
module wp_flag_bank
  import wp_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid_i,
  input  cmd_kind_e kind_i,
  input  logic      ack_i,
  input  logic      stop_i,
  input  logic      wp_pin_i,
  output logic      perm_o,
  output logic      rev_o,
  output logic      commit_o
);

  pend_e pend_q;
  pend_e pend_next;
  logic  perm_q, rev_q, commit_q;

  always_comb begin
    pend_next = PEND_NONE;
    if (ack_i) begin
      unique case (kind_i)
        K_PERM_SET: pend_next = PEND_PERM;
        K_REV_SET:  pend_next = PEND_REV_SET;
        K_REV_CLR:  pend_next = PEND_REV_CLR;
        default:    pend_next = PEND_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q   <= 1'b0;
      rev_q    <= 1'b0;
      commit_q <= 1'b0;
      pend_q   <= PEND_NONE;
    end else begin
      commit_q <= 1'b0;
      if (stop_i && pend_q != PEND_NONE && !wp_pin_i) begin
        commit_q <= 1'b1;
        unique case (pend_q)
          PEND_PERM:    perm_q <= 1'b1;
          PEND_REV_SET: rev_q  <= 1'b1;
          PEND_REV_CLR: rev_q  <= 1'b0;
          default:      ;
        endcase
      end
      if (cmd_valid_i)  pend_q <= pend_next;
      else if (stop_i)  pend_q <= PEND_NONE;
    end
  end

  assign perm_o   = perm_q;
  assign rev_o    = rev_q;
  assign commit_o = commit_q;

  p_perm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  p_no_set_under_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(perm_q) || $rose(rev_q)) |-> !$past(wp_pin_i));

  p_rev_moves_on_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rev_q) |-> commit_q);

  p_commit_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(stop_i));

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  cmd_kind_e         kind_i,
  input  logic              ack_i,
  input  logic              stop_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wp_pin_i,
  input  logic              perm_i,
  input  logic              rev_i,
  output logic              wr_en_o
);

  localparam int HALF_BIT = ADDR_W - 1;

  logic session_q;
  logic wr_en_q;
  logic low_half;

  assign low_half = !wr_addr_i[HALF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      session_q <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      if (cmd_valid_i)  session_q <= ack_i && (kind_i == K_ARR_WR);
      else if (stop_i)  session_q <= 1'b0;
      wr_en_q <= wr_req_i && session_q && !wp_pin_i &&
                 !(low_half && (perm_i || rev_i));
    end
  end

  assign wr_en_o = wr_en_q;

  p_wr_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> $past(wr_req_i));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CLS_W  = 4,
  parameter int DEV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              rw_i,
  input  logic [DEV_W-1:0]  strap_i,
  input  logic              hv_a0_i,
  input  logic              wp_pin_i,
  input  logic              stop_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              dec_valid_o,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic              commit_o
);

  cmd_kind_e kind;
  logic      ack_d;
  logic      perm, rev;
  logic      dec_valid_q, ack_q;

  wp_cmd_classify #(.CLS_W(CLS_W), .DEV_W(DEV_W)) u_classify (
    .cls_i   (cls_i),
    .dev_i   (dev_i),
    .rw_i    (rw_i),
    .strap_i (strap_i),
    .hv_a0_i (hv_a0_i),
    .perm_i  (perm),
    .rev_i   (rev),
    .kind_o  (kind),
    .ack_o   (ack_d)
  );

  wp_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .kind_i      (kind),
    .ack_i       (ack_d),
    .stop_i      (stop_i),
    .wp_pin_i    (wp_pin_i),
    .perm_o      (perm),
    .rev_o       (rev),
    .commit_o    (commit_o)
  );

  wp_write_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .kind_i      (kind),
    .ack_i       (ack_d),
    .stop_i      (stop_i),
    .wr_req_i    (wr_req_i),
    .wr_addr_i   (wr_addr_i),
    .wp_pin_i    (wp_pin_i),
    .perm_i      (perm),
    .rev_i       (rev),
    .wr_en_o     (wr_en_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      dec_valid_q <= cmd_valid_i;
      ack_q       <= cmd_valid_i && ack_d;
    end
  end

  assign dec_valid_o = dec_valid_q;
  assign ack_o       = ack_q;

  p_dec_follows_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> $past(cmd_valid_i));

  p_ack_only_when_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> dec_valid_o);

  p_pin_blocks_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !$past(wp_pin_i));

  p_low_half_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(wr_addr_i[ADDR_W-1]) || !$past(perm || rev)));

  p_perm_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && $past(cls_i == CLS_PROT && !hv_a0_i && dev_i == strap_i && perm))
      |-> !ack_o);

endmodule

// File: tb/wp_guard_tb_top.sv
module wp_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [3:0] cls_i = 4'd0;
  logic [2:0] dev_i = 3'd0;
  logic       rw_i = 1'b0;
  logic [2:0] strap_i = 3'b101;
  logic       hv_a0_i = 1'b0;
  logic       wp_pin_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       wr_req_i = 1'b0;
  logic [7:0] wr_addr_i = 8'd0;
  logic       dec_valid_o, ack_o, wr_en_o, commit_o;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  bit m_perm, m_rev, m_session;
  int m_pend; // 0 none, 1 perm, 2 rev set, 3 rev clear

  always #5 clk = ~clk;

  wp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cls_i(cls_i),
    .dev_i(dev_i), .rw_i(rw_i), .strap_i(strap_i), .hv_a0_i(hv_a0_i),
    .wp_pin_i(wp_pin_i), .stop_i(stop_i), .wr_req_i(wr_req_i),
    .wr_addr_i(wr_addr_i), .dec_valid_o(dec_valid_o), .ack_o(ack_o),
    .wr_en_o(wr_en_o), .commit_o(commit_o)
  );

  function automatic bit exp_ack(input bit [3:0] c, input bit [2:0] d,
                                 input bit r, input bit hv);
    if (c == 4'b1010) return d == strap_i;
    if (c != 4'b0110) return 1'b0;
    if (!hv) return (d == strap_i) && !m_perm;
    if (d == 3'b001) return !m_rev;
    if (d == 3'b011 && !r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_pend(input bit [3:0] c, input bit [2:0] d,
                                  input bit r, input bit hv, input bit a);
    if (!a || r || c != 4'b0110) return 0;
    if (!hv) return 1;
    return (d == 3'b001) ? 2 : 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input bit [3:0] c, input bit [2:0] d, input bit r,
                          input bit hv, input string req);
    bit a;
    a = exp_ack(c, d, r, hv);
    cls_i = c; dev_i = d; rw_i = r; hv_a0_i = hv; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    check(dec_valid_o == 1'b1, "R11", dec_valid_o, 1);
    check(ack_o == a, req, ack_o, a);
    m_pend    = exp_pend(c, d, r, hv, a);
    m_session = a && c == 4'b1010 && !r;
  endtask

  task automatic send_stop(input string req);
    bit cm;
    cm = (m_pend != 0) && !wp_pin_i;
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(commit_o == cm, req, commit_o, cm);
    if (cm) begin
      if (m_pend == 1) m_perm = 1'b1;
      if (m_pend == 2) m_rev  = 1'b1;
      if (m_pend == 3) m_rev  = 1'b0;
    end
    m_pend = 0; m_session = 1'b0;
    @(negedge clk);
    check(commit_o == 1'b0, "R10", commit_o, 0);
  endtask

  task automatic send_wr(input bit [7:0] a, input string req);
    bit e;
    e = m_session && !wp_pin_i && (a[7] || !(m_perm || m_rev));
    wr_addr_i = a; wr_req_i = 1'b1;
    @(negedge clk);
    wr_req_i = 1'b0;
    check(wr_en_o == e, req, wr_en_o, e);
  endtask

  task automatic por();
    rst_n = 1'b0;
    m_perm = 0; m_rev = 0; m_session = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    check(dec_valid_o == 0 && ack_o == 0 && wr_en_o == 0 && commit_o == 0,
          "R11 reset", {dec_valid_o, ack_o, wr_en_o, commit_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    @(negedge clk);
    por();

    // R1: array commands and mismatches
    send_cmd(4'b1010, 3'b101, 1'b1, 1'b0, "R1 match read");
    send_cmd(4'b1010, 3'b100, 1'b0, 1'b0, "R1 mismatch");
    send_cmd(4'b1100, 3'b101, 1'b0, 1'b0, "R1 other class");
    // R2/R3: free writes both halves, then pin high
    send_cmd(4'b1010, 3'b101, 1'b0, 1'b0, "R1 write");
    send_wr(8'h7F, "R2 low open");
    send_wr(8'h80, "R2 high open");
    wp_pin_i = 1'b1;
    send_wr(8'hC3, "R3 pin high");
    wp_pin_i = 1'b0;
    send_stop("R10 no pending");
    send_wr(8'h90, "R3 no session");
    // R6/R8: reversible set, status, repeat set
    send_cmd(4'b0110, 3'b001, 1'b1, 1'b1, "R8 rev status clear");
    send_cmd(4'b0110, 3'b001, 1'b0, 1'b1, "R6 rev set");
    send_stop("R6 commit");
    send_cmd(4'b0110, 3'b001, 1'b1, 1'b1, "R8 rev status set");
    send_cmd(4'b0110, 3'b001, 1'b0, 1'b1, "R6 rev set again");
    send_cmd(4'b1010, 3'b101, 1'b0, 1'b0, "R1 write");
    send_wr(8'h7F, "R2 low blocked rev");
    send_wr(8'h80, "R2 high open rev");
    send_stop("R10");
    // R7: clear, with a dropped one first (R10), and under pin (R9)
    send_cmd(4'b0110, 3'b011, 1'b0, 1'b1, "R7 clear");
    send_cmd(4'b1010, 3'b101, 1'b1, 1'b0, "R10 new start");
    send_stop("R10 dropped");
    wp_pin_i = 1'b1;
    send_cmd(4'b0110, 3'b011, 1'b0, 1'b1, "R9 clear acked under pin");
    send_stop("R9 no commit");
    wp_pin_i = 1'b0;
    send_cmd(4'b0110, 3'b011, 1'b0, 1'b1, "R7 clear");
    send_stop("R7 commit");
    send_cmd(4'b0110, 3'b001, 1'b1, 1'b1, "R8 rev cleared");
    // R4/R5/R9: permanent flag
    wp_pin_i = 1'b1;
    send_cmd(4'b0110, 3'b101, 1'b0, 1'b0, "R9 perm set acked under pin");
    send_stop("R9 perm not set");
    wp_pin_i = 1'b0;
    send_cmd(4'b0110, 3'b101, 1'b1, 1'b0, "R8 perm status clear");
    send_cmd(4'b0110, 3'b100, 1'b0, 1'b0, "R4 strap mismatch");
    send_cmd(4'b0110, 3'b101, 1'b0, 1'b0, "R4 perm set");
    send_stop("R4 commit");
    send_cmd(4'b0110, 3'b101, 1'b1, 1'b0, "R5 perm status");
    send_cmd(4'b0110, 3'b101, 1'b0, 1'b0, "R5 perm set again");
    send_cmd(4'b1010, 3'b101, 1'b0, 1'b0, "R1 write with perm");
    send_wr(8'h00, "R2 low blocked perm");
    send_wr(8'hFF, "R2 high open perm");
    send_stop("R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      bit [2:0] d;
      op = int'($urandom_range(0, 9));
      wp_pin_i = ($urandom_range(0, 3) == 0);
      d = ($urandom_range(0, 2) == 0) ? 3'($urandom) : strap_i;
      case (op)
        0, 1: send_cmd(4'b1010, d, 1'($urandom), 1'b0, "R1 rnd");
        2:    send_cmd(4'($urandom), d, 1'($urandom), 1'($urandom), "R1 rnd any");
        3:    if ($urandom_range(0, 9) == 0)
                send_cmd(4'b0110, d, 1'($urandom), 1'b0, "R4 rnd");
        4:    send_cmd(4'b0110, 3'b001, 1'($urandom), 1'b1, "R6 rnd");
        5:    send_cmd(4'b0110, 3'b011, 1'b0, 1'b1, "R7 rnd");
        6:    send_stop("R10 rnd");
        default: send_wr(8'($urandom), "R2 rnd");
      endcase
      if (i == 300) begin
        wp_pin_i = 1'b0;
        por();
        send_cmd(4'b0110, strap_i, 1'b1, 1'b0, "R5 por clears");
      end
    end
    wp_pin_i = 1'b0;
    send_stop("R10 final");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule